// File: doc/BRIEF.md
# ADC Output Offset and Test-Pattern Multiplexer

This block is the last stage of an ADC digital output path. In normal mode it takes each 10-bit unsigned sample, adds a small signed correction from a 6-bit configuration field, and clamps the result to the 10-bit code range. Any non-zero code on the 3-bit pattern select replaces the data stream with a test pattern. The pattern can be a constant, a two-value toggle, a ramp, a pseudo-random sequence, or a user-programmed 10-bit word. When a pattern is selected, the incoming sample value has no effect on the output.

Samples arrive on a valid/ready stream and leave on a valid/ready stream through one register stage. The input is accepted when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held unchanged. Each accepted input beat produces exactly one output beat. The alternating, ramp and pseudo-random generators advance once per accepted beat. The configuration pins (`cfg_*`) are sampled together with the data on each accepted beat.

Top module: `adc_omux`

## Requirements
- R1: While reset is asserted and after reset is released, `out_valid` is 0, `out_code` is 0 and `in_ready` is 1 until the first beat is accepted.
- R2: With select 000 and offset 0, the output code equals the accepted sample.
- R3: With select 000, the offset is a two's-complement value from -32 to +31, and it is added to the sample.
- R4: With select 000, a sum above 1023 is clamped to 1023.
- R5: With select 000, a sum below 0 is clamped to 0.
- R6: Select 001 outputs 0x200, select 011 outputs 0x000 and select 100 outputs 0x3FF, whatever the sample is.
- R7: Select 010 outputs 0x155 on the first beat after it is chosen, then alternates between 0x2AA and 0x155 on each accepted beat.
- R8: Select 101 outputs the `cfg_user` word sampled with the beat.
- R9: Select 110 outputs a ramp that starts at 0 and increments by 1 per beat, wrapping from 1023 to 0.
- R10: Select 111 outputs the state of a 10-bit LFSR with polynomial x^10+x^7+1. The LFSR starts at 0x001, and each step is next = {q[8:0], q[9]^q[6]}.
- R11: A generator (010, 110 or 111) restarts from its seed whenever the select of an accepted beat differs from the select of the previous accepted beat. It also restarts on the first beat after reset.
- R12: An accepted beat appears on `out_code` with `out_valid` high one cycle after the accepting edge.
- R13: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_code` is unchanged. `in_ready` equals `!out_valid || out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | 10 | Unsigned ADC sample |
| cfg_offset | input | 6 | Signed digital offset |
| cfg_sel | input | 3 | Pattern select (000 = data) |
| cfg_user | input | 10 | User pattern word |
| out_valid | output | 1 | Output code valid |
| out_ready | input | 1 | Downstream accepts the code |
| out_code | output | 10 | Registered output code |

## Verification
The bench drives the extreme offsets against samples near both ends of the range. A design that wraps instead of clamping shows small codes in place of 1023, or large codes in place of 0. A design that zero-extends the offset shows codes that are too high for negative offsets. Every select code is run against a reference model, including a ramp run past its wrap. Selects are also switched away and back, and a generator that does not restart shows a continued sequence in place of its seed. Back-pressure is applied throughout a section of the run, and an output register that loses or changes a held word shows up as a mismatch or an unstable code.

// File: rtl/adc_omux_pkg.sv
package adc_omux_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA = 3'b000,
    SEL_MID  = 3'b001,
    SEL_ALT  = 3'b010,
    SEL_ZERO = 3'b011,
    SEL_ONES = 3'b100,
    SEL_USER = 3'b101,
    SEL_RAMP = 3'b110,
    SEL_PRBS = 3'b111
  } pat_sel_e;
endpackage

// File: rtl/adc_omux_offset.sv
module adc_omux_offset #(
  parameter int W   = 10,
  parameter int OFS = 6
) (
  input  logic [W-1:0]   sample,
  input  logic [OFS-1:0] offset,
  output logic [W-1:0]   result
);
  localparam int SW = W + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << W) - 1);

  logic signed [SW-1:0] a_ext, o_ext, sum;

  always_comb begin
    a_ext = $signed({2'b00, sample});
    o_ext = $signed({{(SW-OFS){offset[OFS-1]}}, offset});
    sum   = a_ext + o_ext;
    if (sum < 0)
      result = '0;
    else if (sum > MAXV)
      result = '1;
    else
      result = sum[W-1:0];
  end
endmodule

// File: rtl/adc_omux_patgen.sv
module adc_omux_patgen
  import adc_omux_pkg::*;
#(
  parameter int          W      = 10,
  parameter logic [W-1:0] SEED  = 1,
  parameter int          TAP_HI = W - 1,
  parameter int          TAP_LO = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  input  pat_sel_e sel,
  input  logic [W-1:0] user,
  output logic [W-1:0] pat
);
  function automatic logic [W-1:0] alt_word();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = (i % 2 == 0);
    return v;
  endfunction

  localparam logic [W-1:0] ALT_A = alt_word();
  localparam logic [W-1:0] ALT_B = ~ALT_A;
  localparam logic [W-1:0] MID   = {1'b1, {(W-1){1'b0}}};

  pat_sel_e     last_sel_q;
  logic         have_q;
  logic [W-1:0] alt_q, ramp_q, lfsr_q;
  logic         fresh;
  logic [W-1:0] cur_alt, cur_ramp, cur_lfsr;

  always_comb begin
    fresh    = !have_q || (sel != last_sel_q);
    cur_alt  = fresh ? ALT_A : alt_q;
    cur_ramp = fresh ? '0    : ramp_q;
    cur_lfsr = fresh ? SEED  : lfsr_q;
    unique case (sel)
      SEL_MID:  pat = MID;
      SEL_ALT:  pat = cur_alt;
      SEL_ZERO: pat = '0;
      SEL_ONES: pat = '1;
      SEL_USER: pat = user;
      SEL_RAMP: pat = cur_ramp;
      SEL_PRBS: pat = cur_lfsr;
      default:  pat = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q     <= 1'b0;
      last_sel_q <= SEL_DATA;
      alt_q      <= ALT_A;
      ramp_q     <= '0;
      lfsr_q     <= SEED;
    end else if (adv) begin
      have_q     <= 1'b1;
      last_sel_q <= sel;
      alt_q      <= (cur_alt == ALT_A) ? ALT_B : ALT_A;
      ramp_q     <= cur_ramp + 1'b1;
      lfsr_q     <= {cur_lfsr[W-2:0], cur_lfsr[TAP_HI] ^ cur_lfsr[TAP_LO]};
    end
  end

  // R10: a nonzero seed with a maximal-length feedback never reaches the all-zero lock state
  a_r10_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/adc_omux.sv
module adc_omux
  import adc_omux_pkg::*;
#(
  parameter int W   = 10,
  parameter int OFS = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_sample,
  input  logic [OFS-1:0] cfg_offset,
  input  logic [2:0]     cfg_sel,
  input  logic [W-1:0]   cfg_user,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_code
);
  pat_sel_e     sel;
  logic         fire;
  logic [W-1:0] adj, pat, nxt;

  assign sel      = pat_sel_e'(cfg_sel);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  adc_omux_offset #(.W(W), .OFS(OFS)) u_ofs (
    .sample (in_sample),
    .offset (cfg_offset),
    .result (adj)
  );

  adc_omux_patgen #(.W(W)) u_pat (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (fire),
    .sel   (sel),
    .user  (cfg_user),
    .pat   (pat)
  );

  assign nxt = (sel == SEL_DATA) ? adj : pat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_code  <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));
  a_r4_nonneg_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel == SEL_DATA && !cfg_offset[OFS-1]) |=> (out_code >= $past(in_sample)));
  a_r5_neg_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel == SEL_DATA && cfg_offset[OFS-1]) |=> (out_code <= $past(in_sample)));
  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel == SEL_ZERO) |=> (out_code == '0));
  a_r8_user: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel == SEL_USER) |=> (out_code == $past(cfg_user)));
endmodule

// File: tb/adc_omux_tb.sv
module adc_omux_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_sample = '0;
  logic [5:0] cfg_offset = '0;
  logic [2:0] cfg_sel = '0;
  logic [9:0] cfg_user = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_code;

  always #10 clk = ~clk;

  adc_omux u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .cfg_offset(cfg_offset), .cfg_sel(cfg_sel),
    .cfg_user(cfg_user), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code)
  );

  typedef struct { logic [9:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;
  bit   stall_en = 0;
  int   cyc = 0;

  bit         m_have = 0;
  logic [2:0] m_last = '0;
  logic [9:0] m_alt = '0, m_ramp = '0, m_lfsr = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] model(input logic [9:0] s, input logic [2:0] sel,
                                        input logic [5:0] ofs, input logic [9:0] usr);
    bit fresh;
    int t;
    logic [9:0] r;
    fresh = !m_have || sel != m_last;
    case (sel)
      3'd0: begin
        t = int'(s) + (ofs[5] ? int'(ofs) - 64 : int'(ofs));
        r = (t < 0) ? 10'd0 : (t > 1023) ? 10'd1023 : 10'(t);
      end
      3'd1: r = 10'h200;
      3'd2: begin r = fresh ? 10'h155 : m_alt; m_alt = (r == 10'h155) ? 10'h2AA : 10'h155; end
      3'd3: r = 10'h000;
      3'd4: r = 10'h3FF;
      3'd5: r = usr;
      3'd6: begin r = fresh ? 10'd0 : m_ramp; m_ramp = r + 10'd1; end
      default: begin r = fresh ? 10'h001 : m_lfsr; m_lfsr = {r[8:0], r[9] ^ r[6]}; end
    endcase
    m_have = 1;
    m_last = sel;
    return r;
  endfunction

  task automatic send(input logic [9:0] s, input logic [2:0] sel, input logic [5:0] ofs,
                      input logic [9:0] usr, input string tag);
    exp_t e;
    @(negedge clk);
    in_sample = s; cfg_sel = sel; cfg_offset = ofs; cfg_user = usr; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    e.v = model(s, sel, ofs, usr);
    e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
  end

  logic       prev_stall = 0;
  logic [9:0] prev_code = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_stall)  // R13 held word stays stable
        check(out_valid && out_code == prev_code, "R13", int'(out_code), int'(prev_code));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R12 unexpected beat", int'(out_code), 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_code == e.v, e.tag, int'(out_code), int'(e.v));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_code  = out_code;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0 && out_code == 0, "R1 in reset", int'(out_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_code == 0 && in_ready == 1, "R1 after reset", int'(out_code), 0);

    send(10'd37, 3'b000, 6'd0, 10'd0, "R2");
    @(negedge clk);
    check(out_valid == 1, "R12 latency", int'(out_valid), 1);
    send(10'd0,    3'b000, 6'd0, 10'd0, "R2");
    send(10'd512,  3'b000, 6'd0, 10'd0, "R2");
    send(10'd1023, 3'b000, 6'd0, 10'd0, "R2");
    send(10'd100,  3'b000, 6'd31, 10'd0, "R3");
    send(10'd100,  3'b000, 6'h20, 10'd0, "R3");
    send(10'd500,  3'b000, 6'h3F, 10'd0, "R3");
    send(10'd1000, 3'b000, 6'd31, 10'd0, "R4");
    send(10'd1023, 3'b000, 6'd31, 10'd0, "R4");
    send(10'd992,  3'b000, 6'd31, 10'd0, "R4");
    send(10'd10,   3'b000, 6'h20, 10'd0, "R5");
    send(10'd0,    3'b000, 6'h3F, 10'd0, "R5");
    send(10'd32,   3'b000, 6'h20, 10'd0, "R5");

    for (int i = 0; i < 3; i++) send(10'(i * 300), 3'b001, 6'd5, 10'd0, "R6");
    for (int i = 0; i < 3; i++) send(10'h3FF, 3'b011, 6'd5, 10'd0, "R6");
    for (int i = 0; i < 3; i++) send(10'h000, 3'b100, 6'd5, 10'd0, "R6");
    for (int i = 0; i < 5; i++) send(10'(i), 3'b010, 6'd0, 10'd0, "R7");
    send(10'd1, 3'b101, 6'd0, 10'h2A5, "R8");
    send(10'd2, 3'b101, 6'd0, 10'h0F0, "R8");

    stall_en = 1;
    for (int i = 0; i < 1030; i++) send(10'd7, 3'b110, 6'd0, 10'd0, "R9");
    for (int i = 0; i < 40; i++) send(10'd9, 3'b111, 6'd0, 10'd0, "R10");

    for (int i = 0; i < 3; i++) send(10'd0, 3'b110, 6'd0, 10'd0, "R11");
    send(10'd44, 3'b000, 6'd0, 10'd0, "R11");
    send(10'd0, 3'b110, 6'd0, 10'd0, "R11");
    for (int i = 0; i < 4; i++) send(10'd0, 3'b111, 6'd0, 10'd0, "R11");
    send(10'd0, 3'b100, 6'd0, 10'd0, "R11");
    send(10'd0, 3'b111, 6'd0, 10'd0, "R11");
    send(10'd0, 3'b010, 6'd0, 10'd0, "R11");
    send(10'd0, 3'b010, 6'd0, 10'd0, "R11");
    send(10'd0, 3'b011, 6'd0, 10'd0, "R11");
    send(10'd0, 3'b010, 6'd0, 10'd0, "R11");
    stall_en = 0;

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R12 drained", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule